// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit translates a 32-bit effective address through a small set of programmable block mappings. Two banks of register pairs exist: one serves instruction fetches and one serves every other access. Each pair holds an upper word (the effective block base, a variable length mask and two privilege enables) and a lower word (the physical block base and a permission code). On a lookup the unit searches the bank that the access type selects. The first usable entry supplies the physical page address and its permission. When nothing matches, a miss is reported, and the surrounding logic must then fall back to page-based translation.

Software loads the mappings one 32-bit word at a time through a write port. That port addresses a bank, an entry index and either the upper or the lower word. The lookup result is registered and appears one cycle after the request.

Top module: `bxl_matcher`

## Requirements
- R1: A lookup with `lk_fetch`=1 searches only the instruction bank (`wr_ibank`=1 when written). A lookup with `lk_fetch`=0 searches only the data bank (`wr_ibank`=0).
- R2: An entry can match only when effective-address bits 31:28 equal upper-word bits 31:28 exactly.
- R3: The length mask is formed by shifting upper-word bits 12:2 left by 15 places, so that it covers address bits 27:17. An entry matches when address bits 27:17, with the mask bits cleared, equal upper-word bits 27:17. A wider mask therefore gives a larger block.
- R4: An entry is usable in supervisor mode (`lk_user`=0) only if upper-word bit 1 is set. It is usable in user mode (`lk_user`=1) only if upper-word bit 0 is set.
- R5: On a hit, `res_paddr` is built as follows:
  - bits 31:28 come from lower-word bits 31:28;
  - bits 27:17 are (address bits 27:17 AND mask) OR lower-word bits 27:17;
  - bits 16:12 come from the address;
  - bits 11:0 are zero.
- R6: On a hit, lower-word bit 1 set gives read/write (`res_rd`=1, `res_wr`=1). Otherwise bit 0 set gives read-only (`res_rd`=1, `res_wr`=0). With neither bit set, the hit has no permission (both 0).
- R7: When several entries match, the entry with the lowest index supplies the result.
- R8: With no usable match, `res_miss`=1, `res_hit`=0, and `res_paddr`, `res_rd` and `res_wr` are all zero.
- R9: Reset clears every register word, so every entry is invalid and every lookup misses. While reset is held, all result outputs are zero.
- R10: A register write takes effect for lookups sampled on the clock edge after the one that performs the write. A lookup sampled on the same edge as the write still sees the old contents.
- R11: A lookup sampled on a clock edge with `lk_vld`=1 drives `res_vld`=1 for exactly the following cycle. With no request, `res_vld`, `res_hit` and `res_miss` are 0 and `res_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ibank | input | 1 | 1 selects the instruction bank, 0 the data bank |
| wr_idx | input | 2 | Entry index within the bank |
| wr_upper | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_data | input | 32 | Word to write |
| lk_vld | input | 1 | Lookup request |
| lk_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| lk_addr | input | 32 | Effective address |
| res_vld | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | A block entry matched |
| res_miss | output | 1 | No entry matched |
| res_paddr | output | 32 | Physical page address (bits 11:0 zero) |
| res_rd | output | 1 | Read permitted |
| res_wr | output | 1 | Write permitted |

## Verification
The hardest case to reach is an address that several entries claim at once, where the winner depends on privilege as well as on index. To build it, the bench loads overlapping entries in the same bank, some enabled only for supervisor mode and some only for user mode. It then issues the same address in both modes, expecting the lowest-indexed usable entry each time. The second hard case is a write and a lookup landing on the same clock edge. The bench drives both in one cycle and checks for the old mapping, then repeats the lookup and expects the new one.

// File: rtl/bxl_pkg.sv
package bxl_pkg;

    localparam int ADDR_W  = 32;
    localparam int PAGE_LSB = 12;
    localparam int PN_W    = ADDR_W - PAGE_LSB;   // 20-bit page number
    localparam int HI_W    = 4;                   // exact-compare field
    localparam int MID_W   = 11;                  // maskable field
    localparam int OFF_W   = 5;                   // pass-through page bits
    localparam int NUM_BANKS = 2;                 // index 1 = fetch bank

    // decoded upper word: only the bits the match logic uses
    typedef struct packed {
        logic [HI_W-1:0]  ea_hi;   // word bits 31:28
        logic [MID_W-1:0] ea_mid;  // word bits 27:17
        logic [MID_W-1:0] len;     // word bits 12:2, aligns with 27:17
        logic             sup_ok;  // word bit 1
        logic             usr_ok;  // word bit 0
    } bxl_upper_t;

    // decoded lower word
    typedef struct packed {
        logic [HI_W-1:0]  pa_hi;   // word bits 31:28
        logic [MID_W-1:0] pa_mid;  // word bits 27:17
        logic             rw;      // word bit 1
        logic             ro;      // word bit 0
    } bxl_lower_t;

    typedef struct packed {
        bxl_upper_t up;
        bxl_lower_t lo;
    } bxl_entry_t;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } bxl_perm_t;

    typedef struct packed {
        logic            hit;
        logic [PN_W-1:0] ppn;
        bxl_perm_t       perm;
    } bxl_result_t;

    function automatic bxl_upper_t unpack_upper(input logic [ADDR_W-1:0] w);
        bxl_upper_t u;
        u.ea_hi  = w[31:28];
        u.ea_mid = w[27:17];
        u.len    = w[12:2];
        u.sup_ok = w[1];
        u.usr_ok = w[0];
        return u;
    endfunction

    function automatic bxl_lower_t unpack_lower(input logic [ADDR_W-1:0] w);
        bxl_lower_t l;
        l.pa_hi  = w[31:28];
        l.pa_mid = w[27:17];
        l.rw     = w[1];
        l.ro     = w[0];
        return l;
    endfunction

    function automatic bxl_perm_t decode_perm(input bxl_lower_t l);
        if (l.rw)      return PERM_RW;
        else if (l.ro) return PERM_RO;
        else           return PERM_NONE;
    endfunction

endpackage

// File: rtl/bxl_regbank.sv
module bxl_regbank
    import bxl_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    wr_ibank,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_upper,
    input  logic [ADDR_W-1:0]       wr_data,
    output bxl_entry_t [NUM_BANKS-1:0][N_ENT-1:0] banks_o
);

    bxl_upper_t up_dec;
    bxl_lower_t lo_dec;
    logic       unused_bits;

    assign up_dec      = unpack_upper(wr_data);
    assign lo_dec      = unpack_lower(wr_data);
    assign unused_bits = ^wr_data[16:13];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar e = 0; e < N_ENT; e++) begin : g_ent
            bxl_entry_t ent_q;
            logic       sel;

            assign sel = wr_en && (wr_ibank == 1'(b)) && (wr_idx == IDX_W'(e));

            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q <= '0;
                end else if (sel) begin
                    if (wr_upper) ent_q.up <= up_dec;
                    else          ent_q.lo <= lo_dec;
                end
            end

            assign banks_o[b][e] = ent_q;
        end
    end

endmodule

// File: rtl/bxl_entry_cmp.sv
module bxl_entry_cmp
    import bxl_pkg::*;
(
    input  bxl_entry_t      ent,
    input  logic [PN_W-1:0] vpn,
    input  logic            user,
    output logic            match,
    output bxl_result_t     res
);

    logic [HI_W-1:0]  a_hi;
    logic [MID_W-1:0] a_mid;
    logic [OFF_W-1:0] a_off;
    logic             priv_ok;

    assign a_hi  = vpn[PN_W-1 -: HI_W];
    assign a_mid = vpn[OFF_W +: MID_W];
    assign a_off = vpn[OFF_W-1:0];

    assign priv_ok = user ? ent.up.usr_ok : ent.up.sup_ok;

    always_comb begin
        match = priv_ok
             && (a_hi == ent.up.ea_hi)
             && ((a_mid & ~ent.up.len) == ent.up.ea_mid);
        res.hit  = match;
        res.ppn  = {ent.lo.pa_hi, (a_mid & ent.up.len) | ent.lo.pa_mid, a_off};
        res.perm = decode_perm(ent.lo);
    end

endmodule

// File: rtl/bxl_prio_sel.sv
module bxl_prio_sel
    import bxl_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic        [N_ENT-1:0] match,
    input  bxl_result_t [N_ENT-1:0] cand,
    output bxl_result_t             sel
);

    // scan from the top so the lowest index is written last and wins
    always_comb begin
        sel = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) sel = cand[i];
        end
    end

endmodule

// File: rtl/bxl_matcher.sv
module bxl_matcher
    import bxl_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_ibank,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_upper,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic               lk_vld,
    input  logic               lk_fetch,
    input  logic               lk_user,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               res_vld,
    output logic               res_hit,
    output logic               res_miss,
    output logic [ADDR_W-1:0]  res_paddr,
    output logic               res_rd,
    output logic               res_wr
);

    bxl_entry_t  [NUM_BANKS-1:0][N_ENT-1:0] banks;
    bxl_entry_t  [N_ENT-1:0]                act_bank;
    logic        [N_ENT-1:0]                match;
    bxl_result_t [N_ENT-1:0]                cand;
    bxl_result_t                            sel;
    bxl_result_t                            res_q;
    logic                                   vld_q;
    logic                                   unused_off;

    assign unused_off = ^lk_addr[PAGE_LSB-1:0];

    bxl_regbank #(.N_ENT(N_ENT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_ibank (wr_ibank),
        .wr_idx   (wr_idx),
        .wr_upper (wr_upper),
        .wr_data  (wr_data),
        .banks_o  (banks)
    );

    // one compare array shared by both banks
    assign act_bank = lk_fetch ? banks[1] : banks[0];

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        bxl_entry_cmp u_cmp (
            .ent   (act_bank[e]),
            .vpn   (lk_addr[ADDR_W-1:PAGE_LSB]),
            .user  (lk_user),
            .match (match[e]),
            .res   (cand[e])
        );
    end

    bxl_prio_sel #(.N_ENT(N_ENT)) u_sel (
        .match (match),
        .cand  (cand),
        .sel   (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= lk_vld;
            res_q <= lk_vld ? sel : '0;
        end
    end

    assign res_vld   = vld_q;
    assign res_hit   = res_q.hit;
    assign res_miss  = vld_q & ~res_q.hit;
    assign res_paddr = {res_q.ppn, {PAGE_LSB{1'b0}}};
    assign res_rd    = res_q.perm[0];
    assign res_wr    = res_q.perm[1];

endmodule

// File: rtl/bxl_matcher_chk.sv
module bxl_matcher_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_vld,
    input logic [31:0] lk_addr,
    input logic        res_vld,
    input logic        res_hit,
    input logic        res_miss,
    input logic [31:0] res_paddr,
    input logic        res_rd,
    input logic        res_wr
);

    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        res_miss |-> (res_paddr == 32'h0 && !res_rd && !res_wr)); // R8

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (res_hit != res_miss)); // R8

    AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        res_wr |-> res_rd); // R6

    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        res_paddr[11:0] == 12'h0); // R5

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (rst)
        lk_vld |=> (!res_hit || res_paddr[16:12] == $past(lk_addr[16:12]))); // R5

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        lk_vld |=> res_vld); // R11

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !lk_vld |=> !res_vld); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> (!res_hit && !res_miss && res_paddr == 32'h0)); // R11

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!res_vld && !res_hit && !res_miss)); // R9

endmodule

bind bxl_matcher bxl_matcher_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_vld    (lk_vld),
    .lk_addr   (lk_addr),
    .res_vld   (res_vld),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_paddr (res_paddr),
    .res_rd    (res_rd),
    .res_wr    (res_wr)
);

// File: tb/sim_bxl_matcher.sv
module sim_bxl_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_ibank = 1'b0;
    logic [1:0]  wr_idx = 2'd0;
    logic        wr_upper = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic        lk_vld = 1'b0;
    logic        lk_fetch = 1'b0;
    logic        lk_user = 1'b0;
    logic [31:0] lk_addr = 32'h0;
    logic        res_vld, res_hit, res_miss, res_rd, res_wr;
    logic [31:0] res_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] sh_up [2][4];
    logic [31:0] sh_lo [2][4];

    always #4 clk = ~clk;   // 125 MHz

    bxl_matcher u0 (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_ibank(wr_ibank), .wr_idx(wr_idx),
        .wr_upper(wr_upper), .wr_data(wr_data),
        .lk_vld(lk_vld), .lk_fetch(lk_fetch), .lk_user(lk_user), .lk_addr(lk_addr),
        .res_vld(res_vld), .res_hit(res_hit), .res_miss(res_miss),
        .res_paddr(res_paddr), .res_rd(res_rd), .res_wr(res_wr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference built from the requirement text: {hit, rd, wr, paddr}
    function automatic logic [34:0] ref_lookup(input logic [31:0] a, input bit fetch, input bit user);
        for (int e = 0; e < 4; e++) begin
            logic [31:0] u, l, m;
            bit ok;
            u  = sh_up[fetch ? 1 : 0][e];
            l  = sh_lo[fetch ? 1 : 0][e];
            m  = (u & 32'h0000_1FFC) << 15;
            ok = user ? u[0] : u[1];
            if (ok && a[31:28] == u[31:28] &&
                ((a & 32'h0FFE_0000 & ~m) == (u & 32'h0FFE_0000))) begin
                return {1'b1, l[1] | l[0], l[1],
                        (l & 32'hF000_0000) | (a & 32'h0FFE_0000 & m) |
                        (l & 32'h0FFE_0000) | (a & 32'h0001_F000)};
            end
        end
        return 35'h0;
    endfunction

    task automatic bus_wr(input bit ib, input int idx, input bit upper, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ibank = ib; wr_idx = 2'(idx); wr_upper = upper; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (upper) sh_up[ib ? 1 : 0][idx] = d;
        else       sh_lo[ib ? 1 : 0][idx] = d;
    endtask

    task automatic check_result(input string tag, input logic [34:0] exp);
        chk({tag, " flags"}, {27'h0, res_vld, res_hit, res_miss, res_rd, res_wr},
            {27'h0, 1'b1, exp[34], !exp[34], exp[33], exp[32]});
        chk({tag, " paddr"}, res_paddr, exp[31:0]);
    endtask

    task automatic look(input string tag, input logic [31:0] a, input bit fetch, input bit user);
        logic [34:0] exp;
        exp = ref_lookup(a, fetch, user);
        @(negedge clk);
        lk_vld = 1'b1; lk_addr = a; lk_fetch = fetch; lk_user = user;
        @(negedge clk);
        lk_vld = 1'b0;
        check_result(tag, exp);
    endtask

    task automatic t_reset();
        chk("R9 outputs idle in reset", {27'h0, res_vld, res_hit, res_miss, res_rd, res_wr}, 32'h0);
        chk("R9 paddr zero in reset", res_paddr, 32'h0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        look("R9 data sup miss after reset", 32'h8000_5000, 1'b0, 1'b0);
        look("R9 fetch user miss after reset", 32'h0000_0000, 1'b1, 1'b1);
        chk("R8 miss expected from model", {31'h0, ref_lookup(32'h0, 1'b1, 1'b1) == 35'h0}, 32'h1);
    endtask

    task automatic t_basic_priv();
        bus_wr(1'b0, 0, 1'b1, 32'h8000_0002);   // supervisor only, 128 KiB
        bus_wr(1'b0, 0, 1'b0, 32'h1000_0002);   // read/write
        look("R5 R6 data sup hit rw", 32'h8000_5ABC, 1'b0, 1'b0);
        chk("R5 paddr literal", res_paddr, 32'h1000_5000);
        look("R4 user blocked by sup-only entry", 32'h8000_5ABC, 1'b0, 1'b1);
        look("R2 top nibble mismatch", 32'h9000_5ABC, 1'b0, 1'b0);
        look("R3 unmasked mid bit mismatch", 32'h8002_5ABC, 1'b0, 1'b0);
    endtask

    task automatic t_bank_sel();
        bus_wr(1'b1, 0, 1'b1, 32'h4000_0002);
        bus_wr(1'b1, 0, 1'b0, 32'h2000_0001);   // read-only
        look("R1 fetch uses instruction bank", 32'h4000_3000, 1'b1, 1'b0);
        chk("R6 read-only literal", {30'h0, res_rd, res_wr}, 32'h2);
        look("R1 data access ignores instruction bank", 32'h4000_3000, 1'b0, 1'b0);
        look("R1 fetch ignores data bank", 32'h8000_5000, 1'b1, 1'b0);
    endtask

    task automatic t_len_mask();
        bus_wr(1'b0, 2, 1'b1, 32'h3000_1FFE);   // full mask, 256 MiB
        bus_wr(1'b0, 2, 1'b0, 32'h5000_0001);
        look("R3 full mask passes mid bits", 32'h3ABC_D123, 1'b0, 1'b0);
        chk("R3 full mask literal", res_paddr, 32'h5ABC_D000);
        bus_wr(1'b0, 3, 1'b1, 32'h6020_000E);   // mask on bits 18:17
        bus_wr(1'b0, 3, 1'b0, 32'h7000_0002);
        look("R3 partial mask hit", 32'h6026_7000, 1'b0, 1'b0);
        chk("R3 partial mask literal", res_paddr, 32'h7006_7000);
        look("R3 partial mask miss outside block", 32'h6028_0000, 1'b0, 1'b0);
    endtask

    task automatic t_priority();
        bus_wr(1'b0, 1, 1'b1, 32'h8000_0003);
        bus_wr(1'b0, 1, 1'b0, 32'hC000_0001);
        look("R7 lowest index wins", 32'h8001_2000, 1'b0, 1'b0);
        chk("R7 winner literal", res_paddr, 32'h1001_2000);
        look("R7 R4 user falls to entry 1", 32'h8001_2000, 1'b0, 1'b1);
        chk("R7 user winner literal", res_paddr, 32'hC001_2000);
        bus_wr(1'b1, 1, 1'b1, 32'h4000_0001);
        bus_wr(1'b1, 1, 1'b0, 32'h9000_0002);
        bus_wr(1'b1, 2, 1'b1, 32'h4000_0002);
        bus_wr(1'b1, 2, 1'b0, 32'hA000_0002);
        look("R7 sup fetch keeps entry 0", 32'h4000_3000, 1'b1, 1'b0);
        look("R7 user fetch takes entry 1", 32'h4000_3000, 1'b1, 1'b1);
    endtask

    task automatic t_perm_none();
        bus_wr(1'b1, 3, 1'b1, 32'hE000_0003);
        bus_wr(1'b1, 3, 1'b0, 32'hB000_0000);
        look("R6 hit without permission", 32'hE001_F000, 1'b1, 1'b1);
        chk("R6 no-permission literal", {29'h0, res_hit, res_rd, res_wr}, 32'h4);
    endtask

    task automatic t_write_timing();
        logic [34:0] exp_old, exp_new;
        bus_wr(1'b0, 3, 1'b0, 32'h0000_0000);
        exp_old = ref_lookup(32'h6026_7000, 1'b0, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_ibank = 1'b0; wr_idx = 2'd3; wr_upper = 1'b0; wr_data = 32'h7000_0002;
        lk_vld = 1'b1; lk_addr = 32'h6026_7000; lk_fetch = 1'b0; lk_user = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; lk_vld = 1'b0;
        check_result("R10 same-edge lookup sees old word", exp_old);
        chk("R10 old literal", res_paddr, 32'h0006_7000);
        sh_lo[0][3] = 32'h7000_0002;
        exp_new = ref_lookup(32'h6026_7000, 1'b0, 1'b0);
        look("R10 next lookup sees new word", 32'h6026_7000, 1'b0, 1'b0);
        chk("R10 new differs from old", {31'h0, exp_new != exp_old}, 32'h1);
    endtask

    task automatic t_pulse();
        look("R11 single result", 32'h8000_0000, 1'b0, 1'b0);
        @(negedge clk);
        chk("R11 valid drops after one cycle", {29'h0, res_vld, res_hit, res_miss}, 32'h0);
        chk("R11 idle paddr zero", res_paddr, 32'h0);
    endtask

    initial begin
        for (int b = 0; b < 2; b++)
            for (int e = 0; e < 4; e++) begin
                sh_up[b][e] = 32'h0;
                sh_lo[b][e] = 32'h0;
            end
        @(negedge clk);
        t_reset();
        t_basic_priv();
        t_bank_sel();
        t_len_mask();
        t_priority();
        t_perm_none();
        t_write_timing();
        t_pulse();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule